// File: doc/BRIEF.md
# Reference DAC Activation Sequencer

This controller runs once per acquisition bring-up. After a start request it quiets the acquisition front end with a fixed series of four register writes: both trigger types are disabled, then the scan sequencer is stopped, then the ADC pacer is switched off. A programmable gap separates these writes; at the default setting it is about 2 µs at 100 MHz. The controller then loads the two reference DACs one after the other: first the positive reference, then the negative one.

After each reference write the controller polls a single busy bit in a status word. It samples that bit a bounded number of times, spaced by the same gap, and moves on when the bit reads clear. If the poll limit runs out, it still moves on, and it records the overrun in a warning flag. A single-cycle done pulse closes the run. Start requests that arrive while a run is in progress have no effect.

Top module: `refdac_init_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `wr_en_o`, `done_o`, `active_o` and `warn_o` are low.
- R2: A start accepted while idle at clock edge S raises `active_o` at S. It then issues four writes with strobes starting at edges S+G, S+2G, S+3G and S+4G, where G is `GAP_CYCLES`. These writes are, in order: address `ADDR_TRIG` data 0x0000, address `ADDR_TRIG` data 0x0010, address `ADDR_ACQ` data 0x0010, and address `ADDR_ACQ` data 0x0030.
- R3: The positive-reference write (address `ADDR_REF`, data 0x0180, which is set bit 7 plus select bit 8) starts one cycle after the last disarm write.
- R4: After a reference write whose strobe starts at edge W, the busy bit is sampled at edges W+1+j·G for j = 0, 1, and so on. At the first sample that reads clear, the next step happens at that same edge. After the positive reference, the next step is the negative-reference write (address `ADDR_REF`, data 0x0080, set bit 7 with bit 8 clear).
- R5: If `POLL_LIMIT` samples in a row all read busy, the sequencer moves on at the edge of the last sample, exactly as if that sample had read clear.
- R6: `done_o` pulses for exactly one cycle, at the step that follows the second poll. In that same cycle `active_o` falls.
- R7: `warn_o` is updated together with `done_o`. It goes high if either poll ran out and low otherwise. It then holds its value until the next accepted start, which clears it.
- R8: A start request while `active_o` is high is ignored: the write order, write timing and done time are unchanged, and no second run follows.
- R9: Only bit `BUSY_BIT` (bit 1) of `status_i` affects the poll; the other bits are ignored.
- R10: Each run issues exactly six write strobes, each one cycle long, all while `active_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run the sequence (level, sampled while idle) |
| status_i | input | STAT_W | Status word holding the reference busy bit |
| active_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| warn_o | output | 1 | A busy poll ran out during the last run |
| wr_en_o | output | 1 | Register write strobe |
| wr_addr_o | output | ADDR_W | Register write address |
| wr_data_o | output | 16 | Register write data |

## Verification
Some properties are checked on every cycle: the reset values, that write strobes occur only inside an active run, that a reference write carries the set bit and one of the two legal codes, that done is a single pulse ending the run, that an active run is never dropped or restarted by a start request, and that the warning flag changes only at done or at an accepted start. The cycle positions of the disarm writes, the exact number of busy samples before each move-on, the boundary at exactly `POLL_LIMIT` samples, and the value of the warning flag can only be shown by the bench's scenarios. To cover these, the bench sweeps the busy duration for both references across and past the poll window, with and without noise on the other status bits and with extra start pulses.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GAP  = 2'd1,
    ST_POLL = 2'd2
  } seq_state_e;

  localparam int STEP_W = 3;

  localparam logic [STEP_W-1:0] STEP_LAST_DISARM = 3'd3;
  localparam logic [STEP_W-1:0] STEP_REF_POS     = 3'd4;
  localparam logic [STEP_W-1:0] STEP_REF_NEG     = 3'd5;

  localparam logic [15:0] CODE_TRIG_ANALOG_OFF = 16'h0000;
  localparam logic [15:0] CODE_TRIG_TTL_OFF    = 16'h0010;
  localparam logic [15:0] CODE_ACQ_SCAN_STOP   = 16'h0010;
  localparam logic [15:0] CODE_ACQ_PACER_OFF   = 16'h0030;
  localparam logic [15:0] CODE_REF_POS         = 16'h0180;
  localparam logic [15:0] CODE_REF_NEG         = 16'h0080;

endpackage

// File: rtl/refseq_step_rom.sv
module refseq_step_rom
  import refseq_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_TRIG = 4'h2,
  parameter logic [ADDR_W-1:0] ADDR_ACQ  = 4'h0,
  parameter logic [ADDR_W-1:0] ADDR_REF  = 4'h6
) (
  input  logic [STEP_W-1:0] step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       data_o
);

  always_comb begin
    addr_o = '0;
    data_o = '0;
    case (step_i)
      3'd0: begin addr_o = ADDR_TRIG; data_o = CODE_TRIG_ANALOG_OFF; end
      3'd1: begin addr_o = ADDR_TRIG; data_o = CODE_TRIG_TTL_OFF;    end
      3'd2: begin addr_o = ADDR_ACQ;  data_o = CODE_ACQ_SCAN_STOP;   end
      3'd3: begin addr_o = ADDR_ACQ;  data_o = CODE_ACQ_PACER_OFF;   end
      3'd4: begin addr_o = ADDR_REF;  data_o = CODE_REF_POS;         end
      3'd5: begin addr_o = ADDR_REF;  data_o = CODE_REF_NEG;         end
      default: begin addr_o = '0; data_o = '0; end
    endcase
  end

endmodule

// File: rtl/refseq_down_timer.sv
module refseq_down_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  input  logic          run_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                       cnt_q <= '0;
    else if (load_i)               cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/refseq_poll_ctr.sv
module refseq_poll_ctr #(
  parameter int LIMIT = 20,
  parameter int PW    = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic inc_i,
  output logic last_o
);

  logic [PW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) idx_q <= '0;
    else if (inc_i)     idx_q <= idx_q + 1'b1;
  end

  assign last_o = (idx_q == PW'(LIMIT - 1));

endmodule

// File: rtl/refdac_init_seq.sv
module refdac_init_seq
  import refseq_pkg::*;
#(
  parameter int GAP_CYCLES = 200,
  parameter int POLL_LIMIT = 20,
  parameter int STAT_W     = 16,
  parameter int BUSY_BIT   = 1,
  parameter int ADDR_W     = 4,
  parameter logic [ADDR_W-1:0] ADDR_TRIG = 4'h2,
  parameter logic [ADDR_W-1:0] ADDR_ACQ  = 4'h0,
  parameter logic [ADDR_W-1:0] ADDR_REF  = 4'h6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              active_o,
  output logic              done_o,
  output logic              warn_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [15:0]       wr_data_o
);

  localparam int TW = $clog2(GAP_CYCLES + 1);
  localparam logic [TW-1:0] GAP_LOAD = TW'(GAP_CYCLES - 1);
  localparam logic [STAT_W-1:0] BUSY_MASK = STAT_W'(1) << BUSY_BIT;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d, issue_idx;
  logic              tmr_load, tmr_zero, tmr_run;
  logic [TW-1:0]     tmr_val;
  logic              poll_clr, poll_inc, poll_last;
  logic              issue, finish, timeout_now, accept, busy;
  logic              warn_acc_q;
  logic [ADDR_W-1:0] rom_addr;
  logic [15:0]       rom_data;

  assign busy    = |(status_i & BUSY_MASK);
  assign accept  = (state_q == ST_IDLE) && start_i;
  assign tmr_run = (state_q != ST_IDLE);

  refseq_down_timer #(.TW(TW)) u_gap (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .zero_o     (tmr_zero)
  );

  refseq_poll_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
    .clk     (clk),
    .rst     (rst),
    .clear_i (poll_clr),
    .inc_i   (poll_inc),
    .last_o  (poll_last)
  );

  refseq_step_rom #(
    .ADDR_W    (ADDR_W),
    .ADDR_TRIG (ADDR_TRIG),
    .ADDR_ACQ  (ADDR_ACQ),
    .ADDR_REF  (ADDR_REF)
  ) u_rom (
    .step_i (issue_idx),
    .addr_o (rom_addr),
    .data_o (rom_data)
  );

  // Next-step decisions: gap expiry issues a write, poll sample either
  // re-arms the gap or moves on (clear bit or limit reached).
  always_comb begin
    state_d     = state_q;
    step_d      = step_q;
    issue       = 1'b0;
    issue_idx   = step_q;
    finish      = 1'b0;
    timeout_now = 1'b0;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    poll_clr    = 1'b0;
    poll_inc    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_GAP;
          step_d   = '0;
          tmr_load = 1'b1;
          tmr_val  = GAP_LOAD;
        end
      end
      ST_GAP: begin
        if (tmr_zero) begin
          issue    = 1'b1;
          tmr_load = 1'b1;
          if (step_q == STEP_REF_POS) begin
            state_d  = ST_POLL;
            tmr_val  = '0;
            poll_clr = 1'b1;
          end else begin
            step_d  = step_q + 3'd1;
            tmr_val = (step_q == STEP_LAST_DISARM) ? '0 : GAP_LOAD;
          end
        end
      end
      ST_POLL: begin
        if (tmr_zero) begin
          if (busy && !poll_last) begin
            poll_inc = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = GAP_LOAD;
          end else begin
            timeout_now = busy;
            if (step_q == STEP_REF_POS) begin
              issue     = 1'b1;
              issue_idx = STEP_REF_NEG;
              step_d    = STEP_REF_NEG;
              tmr_load  = 1'b1;
              tmr_val   = '0;
              poll_clr  = 1'b1;
            end else begin
              finish  = 1'b1;
              state_d = ST_IDLE;
            end
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      warn_acc_q <= 1'b0;
      warn_o     <= 1'b0;
      active_o   <= 1'b0;
      done_o     <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      state_q   <= state_d;
      step_q    <= step_d;
      active_o  <= (state_d != ST_IDLE);
      done_o    <= finish;
      wr_en_o   <= issue;
      wr_addr_o <= issue ? rom_addr : '0;
      wr_data_o <= issue ? rom_data : '0;
      if (accept)           warn_acc_q <= 1'b0;
      else if (timeout_now) warn_acc_q <= 1'b1;
      if (accept)      warn_o <= 1'b0;
      else if (finish) warn_o <= warn_acc_q | timeout_now;
    end
  end

endmodule

// File: rtl/refseq_checks.sv
module refseq_checks #(
  parameter int ADDR_W = 4,
  parameter logic [ADDR_W-1:0] ADDR_REF = 4'h6
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              active_o,
  input logic              done_o,
  input logic              warn_o,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [15:0]       wr_data_o
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!wr_en_o && !done_o && !active_o && !warn_o));

  assert_write_in_run_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> active_o);

  assert_ref_code_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en_o && wr_addr_o == ADDR_REF) |->
      (wr_data_o == 16'h0180 || wr_data_o == 16'h0080));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_ends_run_R6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!active_o && $past(active_o)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (active_o && start_i) |=> (active_o || done_o));

  assert_warn_changes_R7: assert property (@(posedge clk) disable iff (rst)
    (warn_o != $past(warn_o)) |-> (done_o || ($past(start_i) && !$past(active_o))));

endmodule

bind refdac_init_seq refseq_checks #(
  .ADDR_W   (ADDR_W),
  .ADDR_REF (ADDR_REF)
) u_refseq_checks (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .active_o  (active_o),
  .done_o    (done_o),
  .warn_o    (warn_o),
  .wr_en_o   (wr_en_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/test_refdac_init_seq.sv
module test_refdac_init_seq;

  localparam int G = 3;
  localparam int L = 4;
  localparam int BB = 1;
  localparam logic [3:0] A_TRIG = 4'h2;
  localparam logic [3:0] A_ACQ  = 4'h0;
  localparam logic [3:0] A_REF  = 4'h6;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [15:0] status;
  logic active, done, warn, wr_en;
  logic [3:0] wr_addr;
  logic [15:0] wr_data;

  refdac_init_seq #(
    .GAP_CYCLES(G), .POLL_LIMIT(L), .STAT_W(16), .BUSY_BIT(BB), .ADDR_W(4),
    .ADDR_TRIG(A_TRIG), .ADDR_ACQ(A_ACQ), .ADDR_REF(A_REF)
  ) i_refdac_init_seq (
    .clk(clk), .rst(rst), .start_i(start), .status_i(status),
    .active_o(active), .done_o(done), .warn_o(warn),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor and busy model
  logic [3:0]  wa [8];
  logic [15:0] wd [8];
  int wc [8];
  int nwr = 0, done_cyc = 0, hpos = 0, hneg = 0, rem = 0;
  bit done_seen = 0, done_warn = 0, busy = 0, noise = 0;

  assign status = (noise ? ~(16'h1 << BB) : 16'h0) | (busy ? (16'h1 << BB) : 16'h0);

  always @(negedge clk) begin
    if (wr_en) begin
      if (nwr < 8) begin wa[nwr] = wr_addr; wd[nwr] = wr_data; wc[nwr] = cyc; end
      nwr = nwr + 1;
    end
    if (done) begin done_seen = 1; done_cyc = cyc; done_warn = warn; end
    if (wr_en && wr_addr == A_REF) rem = (wr_data == 16'h0180) ? hpos : hneg;
    else if (rem > 0) rem = rem - 1;
    busy = (rem > 0);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int first_clear(input int h);
    return (h + G - 1) / G;
  endfunction

  task automatic run(input int hp, input int hn, input bit nz, input bit extra);
    int s, jp, jn, ep, en, guard;
    bit to;
    hpos = hp; hneg = hn; noise = nz; nwr = 0; done_seen = 0;
    @(negedge clk); start = 1'b1; s = cyc + 1;
    @(negedge clk); start = 1'b0;
    chk(active == 1'b1, "R2 active after start", active, 1);
    chk(warn == 1'b0, "R7 warn cleared by start", warn, 0);
    if (extra) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    guard = 0;
    while (!done_seen && guard < 400) begin @(negedge clk); guard++; end
    @(negedge clk);
    jp = first_clear(hp); jn = first_clear(hn);
    ep = (jp >= L) ? L - 1 : jp;
    en = (jn >= L) ? L - 1 : jn;
    to = (jp >= L) || (jn >= L);
    chk(nwr == 6, "R10 write count", nwr, 6);
    if (nwr == 6) begin
      for (int k = 0; k < 4; k++) begin
        logic [3:0] ea;
        logic [15:0] ed;
        ea = (k < 2) ? A_TRIG : A_ACQ;
        ed = (k == 0) ? 16'h0000 : (k == 3) ? 16'h0030 : 16'h0010;
        chk(wa[k] == ea && wd[k] == ed, "R2 disarm addr/data", int'(wd[k]), int'(ed));
        chk(wc[k] == s + (k + 1) * G, "R2 disarm cycle", wc[k], s + (k + 1) * G);
      end
      chk(wa[4] == A_REF && wd[4] == 16'h0180, "R3 pos ref code", int'(wd[4]), 'h180);
      chk(wc[4] == s + 4 * G + 1, "R3 pos ref cycle", wc[4], s + 4 * G + 1);
      chk(wa[5] == A_REF && wd[5] == 16'h0080, "R4 neg ref code", int'(wd[5]), 'h80);
      chk(wc[5] == wc[4] + 1 + ep * G, (jp >= L) ? "R5 neg ref after timeout" : "R4 neg ref cycle",
          wc[5], wc[4] + 1 + ep * G);
      if (nz) chk(wc[5] == wc[4] + 1 + ep * G, "R9 other status bits ignored", wc[5], wc[4] + 1 + ep * G);
      chk(done_seen && done_cyc == wc[5] + 1 + en * G, (jn >= L) ? "R5 done after timeout" : "R6 done cycle",
          done_cyc, wc[5] + 1 + en * G);
    end
    chk(done_warn == to, "R7 warn at done", done_warn, to);
    chk(done == 1'b0 && active == 1'b0, "R6 done single and run over", {done, active}, 0);
    if (extra) begin
      repeat (2 * G + 4) @(negedge clk);
      chk(nwr == 6 && !active, "R8 extra start ignored", nwr, 6);
    end
    chk(warn == to, "R7 warn held", warn, to);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!wr_en && !done && !active && !warn, "R1 reset outputs", {wr_en, done, active, warn}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!wr_en && !done && !active && !warn, "R1 after reset", {wr_en, done, active, warn}, 0);
    for (int hp = 0; hp <= L * G + 1; hp++)
      for (int hn = 0; hn <= L * G + 1; hn++)
        run(hp, hn, hp[0], ((hp + hn) % 5) == 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule